// File: doc/BRIEF.md
# Cascadable parallel-to-serial converter

This block turns a parallel word into a serial bit stream at the rate of a bit clock. On a load cycle it captures a word of `WORD_W` bits (four by default) into a chain of shift cells. On every other cycle the chain moves one place toward the output. The least significant bit leaves first. All state changes on the falling edge of `bit_clk`. Inputs are sampled at that edge and the serial output changes just after it.

A free-running counter inside the block sets the load cycle. It also drives two word-rate clocks, at one quarter and one eighth of the bit rate for the default width. With `pair_mode` low, a word is loaded every `WORD_W` bit clocks. With `pair_mode` high, a word is loaded every `2*WORD_W` bit clocks, and between loads the serial input is shifted in at the far end of the chain. This lets two instances form a serializer of twice the width. The tail instance's `ser_out` drives the head instance's `ser_in`. The joined stream is the head word followed by the tail word.

`sync` clears the counter asynchronously, which fixes where the next word boundary falls. The stream runs at a fixed rate, so the edge has no valid/ready handshake and no back-pressure. The source must hold `par_in` steady across the falling edge on which it is loaded, and may change it at any other time.

Top module: `p2s_serializer`

## Requirements
- R1: `ser_out`, `word_clk` and `pair_clk` change only on the falling edge of `bit_clk` (or on `sync` for the clocks). `par_in` and `ser_in` are sampled on that falling edge.
- R2: After a load, `ser_out` presents `par_in[0]`, then `par_in[1]`, `par_in[2]` and `par_in[3]` on successive falling edges. Bit 0 is sent first.
- R3: On a non-load falling edge every cell takes the value of its neighbour one place closer to the input end. The cell holding bit 3 takes `ser_in`.
- R4: With `pair_mode` = 0, a load happens on every 4th falling edge.
- R5: With `pair_mode` = 1, a load happens on every 8th falling edge.
- R6: The internal count runs modulo 8, increments on each falling edge, and is 0 while `sync` is high. `word_clk` is count bit 1 (period 4 bit clocks) and `pair_clk` is count bit 2 (period 8 bit clocks).
- R7: `sync` high clears both word clocks at once, without waiting for a clock edge. After release, the first falling edge is a load, and the first word's bit 0 is on `ser_out` from that edge onward.
- R8: With `pair_mode` = 0, `ser_in` has no effect on `ser_out`.
- R9: Two instances in `pair_mode` = 1 are joined by connecting the tail's `ser_out` to the head's `ser_in`, with both on the same `bit_clk` and `sync`. After each joint load, the output is head bits 0..3 followed by tail bits 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; all state moves on its falling edge |
| sync | input | 1 | Asynchronous clear of the word counter, active high |
| pair_mode | input | 1 | 0: load every WORD_W clocks; 1: load every 2*WORD_W clocks |
| par_in | input | WORD_W | Parallel word, bit 0 sent first |
| ser_in | input | 1 | Serial cascade input, enters the far end of the chain |
| ser_out | output | 1 | Serial data output |
| word_clk | output | 1 | Bit clock divided by WORD_W |
| pair_clk | output | 1 | Bit clock divided by 2*WORD_W |

## Verification
A lone instance in 4-bit mode is driven with random words and a random serial input. This shows whether the bit order and load period are right, and whether stray serial-input bits leak into the stream. A second phase holds the words at zero and the serial input at one, so any path from `ser_in` to `ser_out` in 4-bit mode shows up as a one on the output. A two-instance cascade in 8-bit mode is driven with independent random words. It separates a correct chain hand-off from off-by-one shifts and swapped halves. `sync` pulses placed between falling edges and in the middle of a word show that the counter clears at once and that the next edge starts a fresh word.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  typedef enum logic {
    FRAME_SINGLE = 1'b0,
    FRAME_PAIR   = 1'b1
  } frame_mode_e;
endpackage

// File: rtl/p2s_word_counter.sv
module p2s_word_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(negedge clk or posedge clr) begin
    if (clr) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/p2s_load_decode.sv
module p2s_load_decode
  import p2s_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] count,
  input  frame_mode_e      mode,
  output logic             load
);
  logic single_hit;
  logic pair_hit;

  always_comb begin
    single_hit = (count[CNT_W-2:0] == '0);
    pair_hit   = single_hit && !count[CNT_W-1];
    load       = (mode == FRAME_PAIR) ? pair_hit : single_hit;
  end
endmodule

// File: rtl/p2s_shift_cell.sv
module p2s_shift_cell (
  input  logic clk,
  input  logic load,
  input  logic par_bit,
  input  logic chain_bit,
  output logic q
);
  always_ff @(negedge clk) begin
    q <= load ? par_bit : chain_bit;
  end
endmodule

// File: rtl/p2s_serializer.sv
module p2s_serializer
  import p2s_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              bit_clk,
  input  logic              sync,
  input  logic              pair_mode,
  input  logic [WORD_W-1:0] par_in,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              word_clk,
  output logic              pair_clk
);
  localparam int CNT_W = $clog2(2 * WORD_W);

  logic [CNT_W-1:0]  count;
  logic              load_pulse;
  logic [WORD_W-1:0] stage_q;
  frame_mode_e       mode;

  assign mode = frame_mode_e'(pair_mode);

  p2s_word_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (bit_clk),
    .clr   (sync),
    .count (count)
  );

  p2s_load_decode #(.CNT_W(CNT_W)) u_decode (
    .count (count),
    .mode  (mode),
    .load  (load_pulse)
  );

  for (genvar i = 0; i < WORD_W; i++) begin : g_cell
    logic feed;
    if (i == WORD_W - 1) begin : g_far
      assign feed = ser_in;
    end else begin : g_mid
      assign feed = stage_q[i+1];
    end
    p2s_shift_cell u_cell (
      .clk       (bit_clk),
      .load      (load_pulse),
      .par_bit   (par_in[i]),
      .chain_bit (feed),
      .q         (stage_q[i])
    );
  end

  assign ser_out  = stage_q[0];
  assign word_clk = count[CNT_W-2];
  assign pair_clk = count[CNT_W-1];
endmodule

// File: rtl/p2s_serializer_checker.sv
module p2s_serializer_checker #(
  parameter int WORD_W = 4
) (
  input logic              bit_clk,
  input logic              sync,
  input logic              pair_mode,
  input logic [WORD_W-1:0] par_in,
  input logic              ser_out,
  input logic              word_clk,
  input logic              pair_clk,
  input logic              load_pulse
);
  // R2: the word's bit 0 is on the output right after a load
  assert_first_bit_R2: assert property (@(negedge bit_clk) disable iff (sync)
    load_pulse |=> (ser_out == $past(par_in[0])));

  // R4: loads never come on consecutive edges
  assert_no_back_to_back_R4: assert property (@(negedge bit_clk) disable iff (sync)
    load_pulse |=> !load_pulse);

  // R4: a load only falls in the low half of the word clock
  assert_load_phase_R4: assert property (@(negedge bit_clk) disable iff (sync)
    load_pulse |-> !word_clk);

  // R5: in pair mode loads fall only in the low half of the pair clock
  assert_pair_phase_R5: assert property (@(negedge bit_clk) disable iff (sync)
    (load_pulse && pair_mode) |-> !pair_clk);

  // R6: the pair clock rises only when the word clock falls
  assert_divider_R6: assert property (@(negedge bit_clk) disable iff (sync)
    $rose(pair_clk) |-> $fell(word_clk));
endmodule

bind p2s_serializer p2s_serializer_checker #(.WORD_W(WORD_W)) u_chk (
  .bit_clk    (bit_clk),
  .sync       (sync),
  .pair_mode  (pair_mode),
  .par_in     (par_in),
  .ser_out    (ser_out),
  .word_clk   (word_clk),
  .pair_clk   (pair_clk),
  .load_pulse (load_pulse)
);

// File: tb/test_p2s_serializer.sv
module test_p2s_serializer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       sync;
  logic [3:0] s_word, h_word, t_word;
  logic       s_sin, t_sin;
  logic       s_out, h_out, t_out;
  logic       s_wclk, s_pclk, h_wclk, h_pclk, t_wclk, t_pclk;

  p2s_serializer #(.WORD_W(4)) i_p2s_serializer (
    .bit_clk(clk), .sync(sync), .pair_mode(1'b0), .par_in(s_word),
    .ser_in(s_sin), .ser_out(s_out), .word_clk(s_wclk), .pair_clk(s_pclk));

  p2s_serializer #(.WORD_W(4)) i_tail (
    .bit_clk(clk), .sync(sync), .pair_mode(1'b1), .par_in(t_word),
    .ser_in(t_sin), .ser_out(t_out), .word_clk(t_wclk), .pair_clk(t_pclk));

  p2s_serializer #(.WORD_W(4)) i_head (
    .bit_clk(clk), .sync(sync), .pair_mode(1'b1), .par_in(h_word),
    .ser_in(t_out), .ser_out(h_out), .word_clk(h_wclk), .pair_clk(h_pclk));

  int checks = 0;
  int errors = 0;
  int n;
  bit done = 0;
  bit quiet_sin = 0;
  logic [3:0] s_cap, h_cap, t_cap;
  logic exp_s, exp_h;

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (edge %0d)", req, got, exp, n);
    end
  endtask

  task automatic drive();
    if (quiet_sin) begin
      s_word = 4'h0;
      s_sin  = 1'b1;
    end else begin
      s_word = 4'($urandom);
      s_sin  = 1'($urandom);
    end
    h_word = 4'($urandom);
    t_word = 4'($urandom);
    t_sin  = 1'($urandom);
  endtask

  task automatic run(input int cycles, input string tag);
    for (int k = 0; k < cycles; k++) begin
      int p4, p8, c;
      @(negedge clk);
      #1;
      n++;
      p4 = n % 4;
      p8 = n % 8;
      if (p4 == 0) s_cap = s_word;
      if (p8 == 0) begin
        h_cap = h_word;
        t_cap = t_word;
      end
      exp_s = s_cap[p4];
      exp_h = (p8 < 4) ? h_cap[p8] : t_cap[p8-4];
      c = (n + 1) % 8;
      check(s_out, exp_s, quiet_sin ? "R8 sin ignored" : {tag, " R2 R4 order"});
      check(h_out, exp_h, "R9 cascade (R3 R5)");
      check(s_wclk, c[1], "R6 word_clk");
      check(s_pclk, c[2], "R6 pair_clk");
      check(h_pclk, c[2], "R5 pair_clk cascade");
      @(posedge clk);
      check(s_out, exp_s, "R1 stable at rising edge");
      check(h_out, exp_h, "R1 stable at rising edge");
      #1;
      drive();
    end
  endtask

  task automatic sync_pulse();
    #1;
    sync = 1'b1;
    #1;
    check(s_wclk, 1'b0, "R7 async clear word_clk");
    check(s_pclk, 1'b0, "R7 async clear pair_clk");
    check(h_wclk, 1'b0, "R7 async clear head");
    #1;
    sync = 1'b0;
    n = -1;
  endtask

  initial begin
    sync = 1'b1;
    n = -1;
    drive();
    repeat (3) @(posedge clk);
    #1;
    check(s_wclk, 1'b0, "R6 reset word_clk");
    check(s_pclk, 1'b0, "R6 reset pair_clk");
    check(h_pclk, 1'b0, "R6 reset cascade pair_clk");
    #1;
    sync = 1'b0;
    run(203, "R7 first load");
    sync_pulse();
    run(150, "mid-word");
    quiet_sin = 1;
    drive();
    run(64, "R8");
    quiet_sin = 0;
    run(6, "mixed");
    sync_pulse();
    run(101, "resync");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule